// File: doc/BRIEF.md
# Banked Memory Mapper with Split Read/Write Banks

This block sits on the bus of an 8-bit microprocessor that has a 16-bit address, a PHI2 bus clock and an RWB direction line (high for read, low for write). It decodes each address into a RAM select, a ROM select and a select for its own bank register. It widens the SRAM address to 17 bits. It also produces active-low read and write strobes that are qualified by PHI2. The chip selects follow the address alone, so the memory devices can start decoding as soon as the address is valid. Only the strobes wait for PHI2.

The region from $1000 to $7FFF is a banked RAM window. The bank register holds two separate 2-bit bank numbers, one for reads and one for writes. The RWB line picks which of the two applies to the current cycle. Code can therefore copy data from one bank into another without switching banks between the load and the store. The fixed base RAM at $0000-$0FFF always maps to bank 0. The ROM occupies $9000-$FFFF and answers only to reads. The bank register occupies $8400-$840F. It loads data bits 3:0 on the falling PHI2 edge of a write cycle to that range. An active-low reset clears it.

Top module: `bank_mapper`

## Requirements
- R1: For addr in $0000-$0FFF, ram_cs_n is 0 and sram_addr = {2'b00, addr[14:0]} for either RWB value and whatever the bank register holds.
- R2: For addr in $1000-$7FFF with rwb=1, ram_cs_n is 0 and sram_addr = {read bank, addr[14:0]}, where the read bank is bank register bits 1:0.
- R3: For addr in $1000-$7FFF with rwb=0, ram_cs_n is 0 and sram_addr = {write bank, addr[14:0]}, where the write bank is bank register bits 3:2.
- R4: latch_cs_n is 0 exactly for addr in $8400-$840F, for either RWB value.
- R5: On the falling edge of phi2 with rst_n=1, rwb=0 and addr in $8400-$840F, the bank register loads data_in[3:0]. A read of that range, or a write to any other address, leaves the register unchanged. Bits 7:4 of data_in are ignored.
- R6: rom_cs_n is 0 exactly for addr in $9000-$FFFF with rwb=1. A write to that range asserts no select.
- R7: For addresses outside the three mapped ranges ($8000-$83FF and $8410-$8FFF), ram_cs_n, rom_cs_n and latch_cs_n are all 1. At most one select is low at any time.
- R8: rd_n = 0 only when phi2=1 and rwb=1. wr_n = 0 only when phi2=1 and rwb=0. Both strobes are 1 while phi2=0.
- R9: The selects and sram_addr depend only on addr, rwb and the bank register. They take the same values in both phases of phi2.
- R10: While rst_n=0 the bank register holds 0, so both banks are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Bus clock. The bank register loads on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of the bank register |
| rwb | input | 1 | Cycle direction: 1 = read, 0 = write |
| addr | input | 16 | Processor address |
| data_in | input | 8 | Processor data bus. Only bits 3:0 are used |
| ram_cs_n | output | 1 | Active-low SRAM select (base RAM or banked window) |
| rom_cs_n | output | 1 | Active-low ROM select, asserted on reads only |
| latch_cs_n | output | 1 | Active-low bank register select |
| sram_addr | output | 17 | SRAM address: the bank bits above addr[14:0] |
| rd_n | output | 1 | Active-low read strobe qualified by PHI2 |
| wr_n | output | 1 | Active-low write strobe qualified by PHI2 |

## Verification
The bench loads the bank register with different read and write banks and then alternates reads and writes in the window. A design that used one field for both directions would put writes into the read bank. The bench probes the edges of each range: $0FFF/$1000, $7FFF/$8000, $83FF/$8400, $840F/$8410 and $8FFF/$9000. An off-by-one in any of these comparisons would assert the wrong select, or none. The bench also reads the register range, writes unmapped space and writes the ROM range, each with different data, and then re-checks the banks. A design that loaded on any such cycle, or that kept data bits 7:4, would show a changed bank. Every output is compared in both PHI2 phases. This catches selects gated by PHI2 and strobes that are not qualified by it.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

  typedef enum logic [2:0] {
    REG_NONE  = 3'd0,
    REG_BASE  = 3'd1,
    REG_BANK  = 3'd2,
    REG_LATCH = 3'd3,
    REG_ROM   = 3'd4
  } region_e;

  // inclusive range test on a 16-bit bus address
  function automatic logic in_span(input logic [15:0] a,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // assemble the widened SRAM address from a bank number and the low address
  function automatic logic [16:0] join_addr(input logic [1:0]  bank,
                                            input logic [14:0] low);
    return {bank, low};
  endfunction

  // pick the bank field that the current direction uses
  function automatic logic [1:0] pick_bank(input logic       rd_cycle,
                                           input logic [3:0] reg_val);
    return rd_cycle ? reg_val[1:0] : reg_val[3:2];
  endfunction

endpackage

// File: rtl/bmap_region_decode.sv
module bmap_region_decode
  import bmap_pkg::*;
#(
  parameter logic [15:0] BASE_LO  = 16'h0000,
  parameter logic [15:0] BASE_HI  = 16'h0FFF,
  parameter logic [15:0] BANK_LO  = 16'h1000,
  parameter logic [15:0] BANK_HI  = 16'h7FFF,
  parameter logic [15:0] LATCH_LO = 16'h8400,
  parameter logic [15:0] LATCH_HI = 16'h840F,
  parameter logic [15:0] ROM_LO   = 16'h9000,
  parameter logic [15:0] ROM_HI   = 16'hFFFF
) (
  input  logic        phi2,
  input  logic        rst_n,
  input  logic        rwb,
  input  logic [15:0] addr,
  output region_e     region,
  output logic        ram_cs_n,
  output logic        rom_cs_n,
  output logic        latch_cs_n
);

  logic hit_base, hit_bank, hit_latch, hit_rom;

  always_comb begin
    hit_base  = in_span(addr, BASE_LO, BASE_HI);
    hit_bank  = in_span(addr, BANK_LO, BANK_HI);
    hit_latch = in_span(addr, LATCH_LO, LATCH_HI);
    hit_rom   = in_span(addr, ROM_LO, ROM_HI);
  end

  always_comb begin
    if (hit_base)       region = REG_BASE;
    else if (hit_bank)  region = REG_BANK;
    else if (hit_latch) region = REG_LATCH;
    else if (hit_rom)   region = REG_ROM;
    else                region = REG_NONE;
  end

  always_comb begin
    ram_cs_n   = !((region == REG_BASE) || (region == REG_BANK));
    latch_cs_n = !(region == REG_LATCH);
    rom_cs_n   = !((region == REG_ROM) && rwb);
  end

  AST_SEL_EXCL: assert property (@(posedge phi2) disable iff (!rst_n)
    $onehot0({~ram_cs_n, ~rom_cs_n, ~latch_cs_n})); // R7

  AST_ROM_NO_WRITE: assert property (@(posedge phi2) disable iff (!rst_n)
    !rwb |-> rom_cs_n); // R6

endmodule

// File: rtl/bmap_bank_reg.sv
module bmap_bank_reg #(
  parameter int BANK_W = 2,
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * BANK_W
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [REG_W-1:0]  bank_q
);

  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (load_en) bank_q <= data_in[REG_W-1:0];
  end

  AST_REG_HOLD: assert property (@(negedge phi2) disable iff (!rst_n)
    !load_en |=> $stable(bank_q)); // R5

endmodule

// File: rtl/bmap_strobe_gen.sv
module bmap_strobe_gen (
  input  logic phi2,
  input  logic rst_n,
  input  logic rwb,
  output logic rd_n,
  output logic wr_n
);

  always_comb begin
    rd_n = !(phi2 && rwb);
    wr_n = !(phi2 && !rwb);
  end

  AST_STROBE_EXCL: assert property (@(negedge phi2) disable iff (!rst_n)
    rd_n || wr_n); // R8

  AST_STROBE_IDLE: assert property (@(posedge phi2) disable iff (!rst_n)
    rd_n && wr_n); // R8

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int OFF_W  = 15,
  localparam int SRAM_W = BANK_W + OFF_W
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              rwb,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] data_in,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              latch_cs_n,
  output logic [SRAM_W-1:0] sram_addr,
  output logic              rd_n,
  output logic              wr_n
);

  region_e             region;
  logic                reg_load;
  logic [2*BANK_W-1:0] bank_q;
  logic [BANK_W-1:0]   cur_bank;

  bmap_region_decode u_dec (
    .phi2       (phi2),
    .rst_n      (rst_n),
    .rwb        (rwb),
    .addr       (addr),
    .region     (region),
    .ram_cs_n   (ram_cs_n),
    .rom_cs_n   (rom_cs_n),
    .latch_cs_n (latch_cs_n)
  );

  assign reg_load = (region == REG_LATCH) && !rwb;

  bmap_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_reg (
    .phi2    (phi2),
    .rst_n   (rst_n),
    .load_en (reg_load),
    .data_in (data_in),
    .bank_q  (bank_q)
  );

  always_comb begin
    if (region == REG_BASE) cur_bank = '0;
    else                    cur_bank = pick_bank(rwb, bank_q);
    sram_addr = join_addr(cur_bank, addr[OFF_W-1:0]);
  end

  bmap_strobe_gen u_stb (
    .phi2  (phi2),
    .rst_n (rst_n),
    .rwb   (rwb),
    .rd_n  (rd_n),
    .wr_n  (wr_n)
  );

  AST_BASE_BANK0: assert property (@(posedge phi2) disable iff (!rst_n)
    (addr < 16'h1000) |-> (sram_addr[SRAM_W-1:OFF_W] == '0 && !ram_cs_n)); // R1

  AST_SEL_PHASE: assert property (@(posedge phi2) disable iff (!rst_n)
    $stable(addr) && $stable(rwb) && $stable(bank_q) |-> $stable(ram_cs_n) && $stable(rom_cs_n)); // R9

endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/100ps
module tb_bank_mapper;

  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        rwb = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data_in = 8'h00;
  logic        ram_cs_n, rom_cs_n, latch_cs_n, rd_n, wr_n;
  logic [16:0] sram_addr;

  int checks = 0;
  int errors = 0;
  int mdl_rbank = 0;
  int mdl_wbank = 0;

  always #2 phi2 = ~phi2;

  bank_mapper dut (
    .phi2(phi2), .rst_n(rst_n), .rwb(rwb), .addr(addr), .data_in(data_in),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .latch_cs_n(latch_cs_n),
    .sram_addr(sram_addr), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic string req_of(int a, bit rd);
    if (a < 4096) return "R1";
    if (a < 32768) return rd ? "R2" : "R3";
    if (a >= 33792 && a <= 33807) return "R4";
    if (a >= 36864) return "R6";
    return "R7";
  endfunction

  task automatic check(string extra);
    int a;
    bit rd;
    bit e_ram, e_rom, e_lat, e_rd, e_wr;
    int bank, e_sram;
    a  = int'(addr);
    rd = rwb;
    e_ram = !(a < 32768);
    e_lat = !(a >= 33792 && a <= 33807);
    e_rom = !(a >= 36864 && rd);
    e_rd  = !(phi2 && rd);
    e_wr  = !(phi2 && !rd);
    if (a < 4096) bank = 0;
    else bank = rd ? mdl_rbank : mdl_wbank;
    e_sram = bank * 32768 + (a % 32768);
    checks++;
    if (ram_cs_n !== e_ram || rom_cs_n !== e_rom || latch_cs_n !== e_lat ||
        rd_n !== e_rd || wr_n !== e_wr || (e_ram == 0 && int'(sram_addr) != e_sram)) begin
      errors++;
      $display("FAIL %s %s addr=%h rwb=%b phi2=%b: got ram=%b rom=%b lat=%b rd=%b wr=%b sram=%h, expected ram=%b rom=%b lat=%b rd=%b wr=%b sram=%h",
               req_of(a, rd), extra, addr, rwb, phi2, ram_cs_n, rom_cs_n, latch_cs_n,
               rd_n, wr_n, sram_addr, e_ram, e_rom, e_lat, e_rd, e_wr, e_sram[16:0]);
    end
  endtask

  // one bus cycle: inputs change in the low phase, checked in both phases
  task automatic bus(input logic [15:0] a, input logic r, input logic [7:0] d);
    addr = a; rwb = r; data_in = d;
    @(posedge phi2); #1;
    check("R8 high phase");
    @(negedge phi2); #0.2;
    if (!r && int'(a) >= 33792 && int'(a) <= 33807) begin
      mdl_rbank = d % 4;
      mdl_wbank = (d / 4) % 4;
    end
    #0.8;
    check("R9 low phase R5");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    addr = 16'h1234; rwb = 1'b1;
    #3; check("R10 in reset");
    rwb = 1'b0; addr = 16'h8400; data_in = 8'h0F;
    #2; #1.2;  // a falling edge passes while reset is held
    rwb = 1'b1; addr = 16'h5555;
    #0.5; check("R10 write ignored during reset");
    #0.8; rst_n = 1'b1;
    @(negedge phi2); #1;
    bus(16'h1000, 1'b1, 8'h00);   // R10 read bank 0
    bus(16'h7FFF, 1'b0, 8'h00);   // R10 write bank 0
    bus(16'h0000, 1'b1, 8'h00);
    bus(16'h0FFF, 1'b0, 8'h00);
    // R5: read bank 1, write bank 2, upper data bits set
    bus(16'h8400, 1'b0, 8'hF9);
    bus(16'h1000, 1'b1, 8'h00);   // R2
    bus(16'h7FFF, 1'b0, 8'h00);   // R3
    bus(16'h4321, 1'b1, 8'h00);
    bus(16'h4321, 1'b0, 8'h00);
    bus(16'h0FFF, 1'b1, 8'h00);   // R1 with nonzero banks
    bus(16'h0ABC, 1'b0, 8'h00);
    // R5: top of register range, read bank 2, write bank 3
    bus(16'h840F, 1'b0, 8'h0E);
    bus(16'h2000, 1'b1, 8'h00);
    bus(16'h2000, 1'b0, 8'h00);
    // R5: cycles that must not load
    bus(16'h840F, 1'b1, 8'h05);
    bus(16'h8410, 1'b0, 8'h05);
    bus(16'h83FF, 1'b0, 8'h05);
    bus(16'h9000, 1'b0, 8'h05);
    bus(16'h3000, 1'b0, 8'h05);
    bus(16'h6000, 1'b1, 8'h00);
    bus(16'h6000, 1'b0, 8'h00);
    // R6 ROM region
    bus(16'h9000, 1'b1, 8'h00);
    bus(16'hFFFF, 1'b1, 8'h00);
    bus(16'hFFFF, 1'b0, 8'h00);
    // R7 unmapped edges, R4 register range reads
    bus(16'h8000, 1'b1, 8'h00);
    bus(16'h83FF, 1'b1, 8'h00);
    bus(16'h8400, 1'b1, 8'h00);
    bus(16'h8410, 1'b1, 8'h00);
    bus(16'h8FFF, 1'b1, 8'h00);
    bus(16'h8FFF, 1'b0, 8'h00);
    // sweep every bank pair across the window
    for (int p = 0; p < 16; p++) begin
      bus(16'h8407, 1'b0, 8'(p + 16 * p));
      bus(16'(16'h1000 + p * 16'h0700), 1'b1, 8'h00);
      bus(16'(16'h1FFF + p * 16'h0600), 1'b0, 8'h00);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule